// File: doc/BRIEF.md
# Two-Wire Register Access Slave for a Timekeeping Block

This block is the serial front end of a real-time clock. It listens on an I2C-compatible two-wire bus. A host uses it to read and write a bank of sixteen 8-bit registers that hold clock, alarm and control settings. SCL and SDA are sampled by a fast system clock through a two-flop synchronizer. The slave pulls SDA low through an open-drain enable and never drives it high.

After the slave address, the first byte of a write sets the register pointer and a transfer-format code. The pointer advances after every data byte. The host can read in three ways:
- after a repeated start;
- straight after the pointer byte, when the format code selects that shortcut;
- with no pointer write at all, in which case the read begins at the last register.

While the host is addressing the block, the block holds back the seconds tick that would advance the time counters, so that a multi-byte read sees one consistent set of values. A tick that arrives during this time is released once, right after the stop.

Top module: `rtc_bus_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0110010, sent MSB first in bits 7..1 of the first byte after a start; bit 0 selects read (1) or write (0). Any other address is left unacknowledged (SDA stays high on the ninth clock), and the bytes that follow it change no register.
- R2: In a write, the byte after the address byte is acknowledged. Its bits 7..4 load the register pointer and its bits 3..0 load the format code.
- R3: Each further written byte is acknowledged and stored at the pointer, and the pointer then advances by one. Each byte read also advances the pointer.
- R4: After a pointer byte, a repeated start with read address 0x65 returns the register at the pointer, MSB first, one bit per SCL clock.
- R5: When the format code is 4h, the slave starts sending register data on the clock right after the pointer byte's acknowledge, with no repeated start.
- R6: The pointer wraps from Fh to 0h, both for writes and for reads.
- R7: A stop returns the pointer to Fh. A read with no pointer write therefore returns register Fh, then 0h.
- R8: The slave pulls SDA low only during its own acknowledge slots and its own 0 data bits. After the host NACKs a read byte, SDA stays released.
- R9: accessHold rises when the slave's address is matched and falls only after a stop.
- R10: While accessHold is high, tickOut stays low. Any number of secTick pulses in that time produce exactly one tickOut pulse when the hold ends.
- R11: While no access is in progress, tickOut follows secTick in the same cycle.
- R12: After reset, sdaOe, tickOut and accessHold are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| secTick | input | 1 | One-cycle seconds tick from the timebase |
| tickOut | output | 1 | Seconds tick passed on to the time counters |
| accessHold | output | 1 | High while an addressed access is in progress |

## Verification
The hardest case to reach is the hand-off between the hold and the tick. A tick has to arrive more than once in the middle of an addressed write. Then exactly one release pulse has to appear within a few cycles of the stop, and a pulse must never appear inside the access. The bench reaches this by pulsing secTick twice between two data bytes of a bus write. It counts tickOut pulses in a short window that opens when it starts driving the stop condition. A second hard case is the wrap of the shortcut read past Fh. A read with no pointer write reaches it too, because a stop leaves the pointer at Fh.

// File: rtl/rtcbus_pkg.sv
package rtcbus_pkg;

  // Bus conditions seen on the synchronized lines, one cycle each
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } busEvent_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
    logic resetPtr;
    logic addrHit;
    logic busStop;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDATA,
    ST_WACK,
    ST_TX,
    ST_MACK,
    ST_MACKF,
    ST_IGNORE
  } busState_t;

endpackage

// File: rtl/rtcbus_sync.sv
module rtcbus_sync
  import rtcbus_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  output logic      sdaS,
  output busEvent_t ev
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;
  logic              sclS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS = sclPipe[STAGES-1];
  assign sdaS = sdaPipe[STAGES-1];

  always_comb begin
    ev.start = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stop  = sclS & sclPrev & ~sdaPrev & sdaS;
    ev.rise  = sclS & ~sclPrev;
    ev.fall  = ~sclS & sclPrev;
  end

endmodule

// File: rtl/rtcbus_ctrl.sv
module rtcbus_ctrl
  import rtcbus_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'b0110010
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvent_t         ev,
  input  logic              sdaS,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              fmtShort,
  input  logic              txMsb,
  output dpStrobe_t         stb,
  output logic              sdaOe,
  output busState_t         stateOut
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(DATA_W - 1);

  busState_t        state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitNext;
  logic             rdMode, rdNext;
  logic             byteDone;

  assign byteDone = ev.fall && (bitCnt == BYTE_END);

  always_comb begin
    stb       = '0;
    stateNext = state;
    bitNext   = bitCnt;
    rdNext    = rdMode;
    if (ev.stop) begin
      stateNext    = ST_IDLE;
      stb.resetPtr = 1'b1;
      stb.busStop  = 1'b1;
    end else if (ev.start) begin
      stateNext = ST_ADDR;
      bitNext   = '0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (ev.rise) begin
            stb.shiftIn = 1'b1;
            bitNext     = bitCnt + 1'b1;
          end else if (byteDone) begin
            if (state == ST_ADDR) begin
              if (rxByte[DATA_W-1:1] == SLAVE_ADDR) begin
                stateNext   = ST_AACK;
                stb.addrHit = 1'b1;
                rdNext      = rxByte[0];
              end else begin
                stateNext = ST_IGNORE;
              end
            end else if (state == ST_PTR) begin
              stb.loadPtr = 1'b1;
              stateNext   = ST_PACK;
            end else begin
              stb.writeReg = 1'b1;
              stateNext    = ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (ev.fall) begin
            bitNext = '0;
            if (rdMode) begin
              stb.loadTx = 1'b1;
              stateNext  = ST_TX;
            end else begin
              stateNext = ST_PTR;
            end
          end
        end
        ST_PACK: begin
          if (ev.fall) begin
            bitNext = '0;
            if (fmtShort) begin
              stb.loadTx = 1'b1;
              stateNext  = ST_TX;
            end else begin
              stateNext = ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (ev.fall) begin
            bitNext   = '0;
            stateNext = ST_WDATA;
          end
        end
        ST_TX: begin
          if (ev.fall) begin
            if (bitCnt == TX_LAST) begin
              stateNext = ST_MACK;
              bitNext   = '0;
            end else begin
              stb.shiftTx = 1'b1;
              bitNext     = bitCnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (ev.rise) stateNext = sdaS ? ST_IGNORE : ST_MACKF;
        end
        ST_MACKF: begin
          if (ev.fall) begin
            stb.loadTx = 1'b1;
            stateNext  = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      rdMode <= 1'b0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitNext;
      rdMode <= rdNext;
    end
  end

  assign sdaOe = (state == ST_AACK) || (state == ST_PACK) || (state == ST_WACK) ||
                 ((state == ST_TX) && !txMsb);
  assign stateOut = state;

endmodule

// File: rtl/rtcbus_datapath.sv
module rtcbus_datapath
  import rtcbus_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter int         PTR_W     = 4,
  parameter logic [3:0] SHORT_FMT = 4'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaS,
  input  logic              secTick,
  output logic [DATA_W-1:0] rxByte,
  output logic              fmtShort,
  output logic              txMsb,
  output logic [PTR_W-1:0]  ptrVal,
  output logic              holdQ,
  output logic              pendingTick,
  output logic              tickOut
);

  localparam int DEPTH = 1 << PTR_W;
  localparam int FMT_W = DATA_W - PTR_W;

  logic [DATA_W-1:0] bank [DEPTH];
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic [PTR_W-1:0]  ptr;
  logic [FMT_W-1:0]  fmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '1;
      fmt     <= '0;
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[DATA_W-2:0], sdaS};
      if (stb.resetPtr) begin
        ptr <= '1;
        fmt <= '0;
      end else if (stb.loadPtr) begin
        ptr <= rxShift[DATA_W-1 -: PTR_W];
        fmt <= rxShift[FMT_W-1:0];
      end else if (stb.writeReg) begin
        bank[ptr] <= rxShift;
        ptr       <= ptr + 1'b1;
      end else if (stb.loadTx) begin
        txShift <= bank[ptr];
        ptr     <= ptr + 1'b1;
      end
      if (stb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  // Carry hold and deferred seconds tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ       <= 1'b0;
      pendingTick <= 1'b0;
    end else begin
      if (stb.busStop)      holdQ <= 1'b0;
      else if (stb.addrHit) holdQ <= 1'b1;
      if (holdQ && secTick) pendingTick <= 1'b1;
      else if (!holdQ)      pendingTick <= 1'b0;
    end
  end

  assign tickOut  = !holdQ && (secTick || pendingTick);
  assign rxByte   = rxShift;
  assign fmtShort = (fmt == FMT_W'(SHORT_FMT));
  assign txMsb    = txShift[DATA_W-1];
  assign ptrVal   = ptr;

endmodule

// File: rtl/rtc_bus_slave.sv
module rtc_bus_slave
  import rtcbus_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'b0110010,
  parameter int         DATA_W      = 8,
  parameter int         PTR_W       = 4,
  parameter logic [3:0] SHORT_FMT   = 4'h4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic secTick,
  output logic tickOut,
  output logic accessHold
);

  busEvent_t         ev;
  dpStrobe_t         stb;
  busState_t         ctrlState;
  logic              sdaS;
  logic [DATA_W-1:0] rxByte;
  logic              fmtShort;
  logic              txMsb;
  logic [PTR_W-1:0]  ptrVal;
  logic              pendingTick;

  rtcbus_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaS(sdaS), .ev(ev)
  );

  rtcbus_ctrl #(.DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .ev(ev), .sdaS(sdaS), .rxByte(rxByte),
    .fmtShort(fmtShort), .txMsb(txMsb), .stb(stb), .sdaOe(sdaOe),
    .stateOut(ctrlState)
  );

  rtcbus_datapath #(.DATA_W(DATA_W), .PTR_W(PTR_W), .SHORT_FMT(SHORT_FMT)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaS), .secTick(secTick),
    .rxByte(rxByte), .fmtShort(fmtShort), .txMsb(txMsb), .ptrVal(ptrVal),
    .holdQ(accessHold), .pendingTick(pendingTick), .tickOut(tickOut)
  );

endmodule

// File: rtl/rtc_bus_slave_checker.sv
module rtc_bus_slave_checker
  import rtcbus_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sdaOe,
  input logic             tickOut,
  input logic             accessHold,
  input busState_t        ctrlState,
  input logic [PTR_W-1:0] ptrVal,
  input logic             pendingTick,
  input dpStrobe_t        stb
);

  assert_ack_after_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.addrHit |=> sdaOe);

  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.writeReg || stb.loadTx) && (ptrVal == '1)) |=> (ptrVal == '0));

  assert_ptr_rewind_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.busStop |=> (ptrVal == '1));

  assert_released_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlState == ST_IDLE) || (ctrlState == ST_IGNORE)) |-> !sdaOe);

  assert_hold_ends_on_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accessHold) |-> $past(stb.busStop));

  assert_tick_blocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    accessHold |-> !tickOut);

  assert_pending_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(accessHold) && pendingTick) |-> tickOut);

endmodule

bind rtc_bus_slave rtc_bus_slave_checker #(.PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .tickOut(tickOut),
  .accessHold(accessHold), .ctrlState(ctrlState), .ptrVal(ptrVal),
  .pendingTick(pendingTick), .stb(stb)
);

// File: tb/rtc_bus_slave_test.sv
module rtc_bus_slave_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic secTick = 1'b0;
  logic sdaOe, tickOut, accessHold;
  logic sdaWire;

  assign sdaWire = sdaDrv & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bus_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaWire), .sdaOe(sdaOe),
    .secTick(secTick), .tickOut(tickOut), .accessHold(accessHold)
  );

  int   checks = 0;
  int   fails = 0;
  int   relTicks = 0;
  logic busWin = 1'b0;
  logic relWin = 1'b0;
  logic quiet = 1'b0;
  logic done = 1'b0;
  logic [7:0] model [16];
  logic ack;
  logic [7:0] rd;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference behaviour of the tick path and bus release, compared every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (quiet) begin
        checks++;
        if (sdaOe !== 1'b0) begin
          fails++;
          $display("FAIL R8 slave drives during host bit actual=%0b expected=0", sdaOe);
        end
      end
      if (busWin) begin
        checks++;
        if (tickOut !== 1'b0 || accessHold !== 1'b1) begin
          fails++;
          $display("FAIL R9/R10 in access actual tick=%0b hold=%0b expected tick=0 hold=1",
                   tickOut, accessHold);
        end
      end else if (!relWin) begin
        checks++;
        if (tickOut !== secTick) begin
          fails++;
          $display("FAIL R11 idle tick actual=%0b expected=%0b", tickOut, secTick);
        end
      end else if (tickOut) begin
        relTicks++;
      end
    end
  end

  task automatic busStart();
    sdaDrv = 1'b1; tick(4);
    sclDrv = 1'b1; tick(8);
    sdaDrv = 1'b0; tick(8);
    sclDrv = 1'b0; tick(4);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(4);
    sclDrv = 1'b1; tick(8);
    sdaDrv = 1'b1; tick(8);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; quiet = 1'b1; tick(4);
      sclDrv = 1'b1; tick(8);
      sclDrv = 1'b0; tick(1);
      quiet = 1'b0; tick(3);
    end
    sdaDrv = 1'b1; tick(4);
    sclDrv = 1'b1; tick(4);
    a = sdaWire; tick(4);
    sclDrv = 1'b0; tick(4);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(6);
      sclDrv = 1'b1; tick(4);
      b[i] = sdaWire; tick(4);
      sclDrv = 1'b0;
    end
    tick(4);
    sdaDrv = nack; tick(4);
    sclDrv = 1'b1; tick(8);
    sclDrv = 1'b0; tick(4);
    sdaDrv = 1'b1;
  endtask

  task automatic endAccess(input int expTicks);
    busWin = 1'b0;
    relWin = 1'b1;
    relTicks = 0;
    busStop();
    tick(4);
    relWin = 1'b0;
    check("R10 release ticks", relTicks, expTicks);
    check("R9 hold after stop", accessHold, 1'b0);
  endtask

  task automatic pulseTick();
    secTick = 1'b1; tick(1);
    secTick = 1'b0; tick(2);
  endtask

  initial begin
    for (int r = 0; r < 16; r++) model[r] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(2);
    check("R12 sdaOe", sdaOe, 1'b0);
    check("R12 tickOut", tickOut, 1'b0);
    check("R12 accessHold", accessHold, 1'b0);

    // R11: tick passes straight through when idle
    secTick = 1'b1;
    @(negedge clk);
    check("R11 pass-through", tickOut, 1'b1);
    tick(1);
    secTick = 1'b0;
    tick(4);

    // Write at pointer 3, two ticks during the access
    busStart();
    sendByte(8'h64, ack); check("R1 address ack", ack, 1'b0);
    busWin = 1'b1;
    sendByte(8'h30, ack); check("R2 pointer byte ack", ack, 1'b0);
    sendByte(8'hA1, ack); check("R3 data ack", ack, 1'b0); model[3] = 8'hA1;
    pulseTick();
    pulseTick();
    check("R9 hold during access", accessHold, 1'b1);
    sendByte(8'hB2, ack); check("R3 second data ack", ack, 1'b0); model[4] = 8'hB2;
    endAccess(1);

    // Write wrapping past Fh
    busStart();
    sendByte(8'h64, ack); check("R1 address ack", ack, 1'b0);
    busWin = 1'b1;
    sendByte(8'hF0, ack); check("R2 pointer byte ack", ack, 1'b0);
    sendByte(8'h5A, ack); check("R6 data at Fh ack", ack, 1'b0); model[15] = 8'h5A;
    sendByte(8'hC3, ack); check("R6 data at 0h ack", ack, 1'b0); model[0] = 8'hC3;
    endAccess(0);

    // Foreign address: ignored, would write 77 to reg 3 if decoded
    busStart();
    sendByte(8'hC8, ack); check("R1 foreign nack", ack, 1'b1);
    sendByte(8'h30, ack); check("R1 foreign byte nack", ack, 1'b1);
    sendByte(8'h77, ack); check("R1 foreign data nack", ack, 1'b1);
    check("R1 no hold for foreign", accessHold, 1'b0);
    busStop();
    tick(4);

    // Standard read with repeated start; reg 3 also proves R1 left it alone
    busStart();
    sendByte(8'h64, ack);
    busWin = 1'b1;
    sendByte(8'h30, ack); check("R2 pointer ack", ack, 1'b0);
    busStart();
    sendByte(8'h65, ack); check("R4 read address ack", ack, 1'b0);
    recvByte(1'b0, rd); check("R4 read reg 3 (R1 unchanged)", rd, model[3]);
    recvByte(1'b1, rd); check("R3 read increments to reg 4", rd, model[4]);
    check("R8 released after nack", sdaOe, 1'b0);
    endAccess(0);

    // Standard read wrapping past Fh
    busStart();
    sendByte(8'h64, ack);
    busWin = 1'b1;
    sendByte(8'hF0, ack);
    busStart();
    sendByte(8'h65, ack);
    recvByte(1'b0, rd); check("R6 read reg F", rd, model[15]);
    recvByte(1'b1, rd); check("R6 read wraps to reg 0", rd, model[0]);
    endAccess(0);

    // Shortcut read, format 4h
    busStart();
    sendByte(8'h64, ack);
    busWin = 1'b1;
    sendByte(8'h34, ack); check("R5 shortcut pointer ack", ack, 1'b0);
    recvByte(1'b0, rd); check("R5 shortcut reg 3", rd, model[3]);
    recvByte(1'b1, rd); check("R5 shortcut reg 4", rd, model[4]);
    check("R8 released after nack", sdaOe, 1'b0);
    endAccess(0);

    // Read with no pointer write starts at Fh
    busStart();
    sendByte(8'h65, ack); check("R7 read address ack", ack, 1'b0);
    busWin = 1'b1;
    recvByte(1'b0, rd); check("R7 first byte from Fh", rd, model[15]);
    recvByte(1'b1, rd); check("R7 then 0h", rd, model[0]);
    endAccess(0);

    // Shortcut read across the wrap
    busStart();
    sendByte(8'h64, ack);
    busWin = 1'b1;
    sendByte(8'hF4, ack);
    recvByte(1'b0, rd); check("R6 shortcut reg F", rd, model[15]);
    recvByte(1'b1, rd); check("R6 shortcut wraps to reg 0", rd, model[0]);
    endAccess(0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule